// File: doc/BRIEF.md
# Programmable CPU Clock Speed Selector

This block turns one fast base clock into the clock that drives a small CPU. A free-running binary counter divides the base clock, and an eight-way selector picks the CPU clock from two kinds of source. One is the base clock itself. The others are the seven upper counter bits, and the divide-by-two bit is left out. A small speed register chooses the source. The register is written from a data nibble when the active-low write strobe is low at a base-clock edge. The register also carries one bit that has nothing to do with speed: it is passed out as the on/off enable of a segment display.

The block drives two clocks. The true clock feeds the CPU's latching logic and the complementary clock feeds its step counter. A halt input parks both clocks: the true clock is held low and the complement is held high. The divider keeps counting during a halt, so the phase of the divided clock is kept. At reset the register comes up at full speed with the display off.

Top module: `cks_clock_select`

## Requirements
- R1: The divider counter starts at 0 after reset and goes up by one on every base-clock edge, halt or not.
- R2: Speed code 7 (register bits [2:0] = 3'b111) passes the base clock straight through, giving a period of one base cycle.
- R3: Speed code n, for n from 0 to 6, selects counter bit 7-n. The period is 2^(8-n) base cycles with a 50% duty cycle, so code 0 is base/256 and code 6 is base/4. Counter bit 0 can never be selected.
- R4: When `wr_n` is low at a base-clock rising edge, the register loads `wr_data[3:0]` at that edge. Bits [2:0] hold the speed code and bit 3 holds the display enable. The new value is visible right after that edge and not before it.
- R5: While `wr_n` is high, changes on `wr_data` have no effect on the register, the display enable or the clock period.
- R6: Register bit 3 drives `disp_en` and does not affect the selected speed.
- R7: While `halt` is low, `cpu_clk_n` is always the inverse of `cpu_clk`.
- R8: While `halt` is high, `cpu_clk` is 0 and `cpu_clk_n` is 1. The counter keeps running, so rising edges that follow the halt stay in phase with the edges that came before it.
- R9: Asynchronous active-low reset, released in step with the base clock, sets the register to 4'b0111. The block then runs at full speed with `disp_en` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Active-high clock stop |
| wr_n | input | 1 | Active-low speed-register write strobe |
| wr_data | input | 4 | Nibble for the speed register: [2:0] speed code, [3] display enable |
| cpu_clk | output | 1 | Selected CPU clock, low while halted |
| cpu_clk_n | output | 1 | Complement of the CPU clock, high while halted |
| disp_en | output | 1 | Segment display on/off enable |

## Verification
The bench measures the period and high time for all eight codes. Reversing the code-to-bit order, selecting bit 0, or sending code 7 to a counter bit would each give a wrong period for at least one code. It probes the display bit just before and just after the write edge, so a register that loads one edge late, or that ignores the strobe, is caught. It also checks that a display-bit write leaves the speed unchanged. After a halt that lasts a number of cycles that is not a multiple of the period, it checks that rising edges still land on the old phase grid. A divider that froze during the halt would shift that grid.

// File: rtl/cks_pkg.sv
package cks_pkg;
  localparam int unsigned CKS_CNT_W = 8;
  localparam int unsigned CKS_SEL_W = 3;
  localparam int unsigned CKS_REG_W = CKS_SEL_W + 1;
endpackage

// File: rtl/cks_rst_sync.sv
module cks_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/cks_div_counter.sv
module cks_div_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cks_speed_reg.sv
module cks_speed_reg #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned REG_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] reg_o
);
  localparam logic [REG_W-1:0] RST_VAL = {1'b0, {SEL_W{1'b1}}};

  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_d;
  logic             load_en;

  always_comb begin
    load_en = ~wr_n;
    reg_d   = load_en ? wr_data : reg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= RST_VAL;
    else        reg_q <= reg_d;
  end

  assign reg_o = reg_q;
endmodule

// File: rtl/cks_tap_mux.sv
module cks_tap_mux #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NTAP = 1 << SEL_W,
  localparam int unsigned UPW  = CNT_W - 1
) (
  input  logic             base_clk,
  input  logic [UPW-1:0]   cnt_up,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_clk
);
  logic [NTAP-1:0] taps;

  generate
    for (genvar i = 0; i < NTAP - 1; i++) begin : g_tap
      assign taps[i] = cnt_up[UPW-1-i];
    end
  endgenerate
  assign taps[NTAP-1] = base_clk;

  assign sel_clk = taps[sel];
endmodule

// File: rtl/cks_clock_select.sv
module cks_clock_select
  import cks_pkg::*;
#(
  parameter int unsigned CNT_W = CKS_CNT_W,
  parameter int unsigned SEL_W = CKS_SEL_W,
  localparam int unsigned REG_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             wr_n,
  input  logic [REG_W-1:0] wr_data,
  output logic             cpu_clk,
  output logic             cpu_clk_n,
  output logic             disp_en
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] spd_q;
  logic             sel_clk;

  cks_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cks_div_counter #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cnt_o (cnt_q)
  );

  cks_speed_reg #(.SEL_W(SEL_W)) u_spd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_n    (wr_n),
    .wr_data (wr_data),
    .reg_o   (spd_q)
  );

  cks_tap_mux #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_mux (
    .base_clk (clk),
    .cnt_up   (cnt_q[CNT_W-1:1]),
    .sel      (spd_q[SEL_W-1:0]),
    .sel_clk  (sel_clk)
  );

  always_comb begin
    cpu_clk   = sel_clk & ~halt;
    cpu_clk_n = ~sel_clk | halt;
    disp_en   = spd_q[REG_W-1];
  end
endmodule

module cks_clock_select_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned REG_W = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             halt,
  input logic             wr_n,
  input logic [REG_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt,
  input logic [REG_W-1:0] spd,
  input logic             cpu_clk,
  input logic             cpu_clk_n,
  input logic             disp_en
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> cnt == $past(cnt) + 1'b1);

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_n |=> spd == $past(wr_data));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_n |=> $stable(spd) && $stable(disp_en));

  a_r7_complement: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !halt |-> cpu_clk_n == !cpu_clk);

  a_r8_parked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halt |-> !cpu_clk && cpu_clk_n);

  a_r8_count_runs: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halt |=> cnt != $past(cnt));
endmodule

bind cks_clock_select cks_clock_select_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .halt       (halt),
  .wr_n       (wr_n),
  .wr_data    (wr_data),
  .cnt        (cnt_q),
  .spd        (spd_q),
  .cpu_clk    (cpu_clk),
  .cpu_clk_n  (cpu_clk_n),
  .disp_en    (disp_en)
);

// File: tb/sim_cks_clock_select.sv
`timescale 1ns/1ps
module sim_cks_clock_select;
  logic       clk;
  logic       rst_n;
  logic       halt;
  logic       wr_n;
  logic [3:0] wr_data;
  logic       cpu_clk;
  logic       cpu_clk_n;
  logic       disp_en;

  int checks;
  int errors;
  int done_cnt;
  int req_cnt;
  bit finished;

  typedef struct {
    longint per_ns;
    string  tag;
  } exp_t;
  exp_t sb_q[$];

  cks_clock_select u0 (
    .clk(clk), .rst_n(rst_n), .halt(halt), .wr_n(wr_n), .wr_data(wr_data),
    .cpu_clk(cpu_clk), .cpu_clk_n(cpu_clk_n), .disp_en(disp_en)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk);
    wr_data = v;
    wr_n    = 1'b0;
    @(negedge clk);
    wr_n    = 1'b1;
  endtask

  // Driver side of the scoreboard: push expected period, wait for monitor
  task automatic expect_period(input longint cycles, input string tag);
    exp_t e;
    e.per_ns = cycles * 10;
    e.tag    = tag;
    sb_q.push_back(e);
    req_cnt++;
    wait (done_cnt == req_cnt);
  endtask

  // Monitor side: measure period and high time of cpu_clk
  initial begin
    exp_t   e;
    longint t1, th, t2;
    forever begin
      wait (sb_q.size() > 0);
      e = sb_q.pop_front();
      @(posedge cpu_clk);
      @(posedge cpu_clk);
      t1 = longint'($time);
      @(negedge cpu_clk);
      th = longint'($time);
      @(posedge cpu_clk);
      t2 = longint'($time);
      chk((t2 - t1) == e.per_ns, {e.tag, " period"}, t2 - t1, e.per_ns);
      chk((th - t1) == e.per_ns / 2, {e.tag, " high time"}, th - t1, e.per_ns / 2);
      done_cnt++;
    end
  end

  initial begin
    #3ms;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint t0, tr;
    rst_n = 1'b0; halt = 1'b0; wr_n = 1'b1; wr_data = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state, full speed, display off
    chk(disp_en == 1'b0, "R9 disp_en after reset", disp_en, 0);
    expect_period(1, "R9/R2 reset full speed");
    @(negedge clk);
    chk(cpu_clk_n == ~cpu_clk, "R7 complement after reset", cpu_clk_n, ~cpu_clk);

    // R4: load timing probe on the display bit
    @(negedge clk);
    wr_data = 4'b1111;
    wr_n    = 1'b0;
    #4;
    chk(disp_en == 1'b0, "R4 not visible before edge", disp_en, 0);
    #2;
    chk(disp_en == 1'b1, "R4 visible after edge", disp_en, 1);
    @(negedge clk);
    wr_n = 1'b1;
    expect_period(1, "R2/R6 code 7 with display on");

    // R3/R2: every speed code
    for (int c = 0; c < 7; c++) begin
      wr(4'(c));
      chk(disp_en == 1'b0, "R6 display cleared by write", disp_en, 0);
      expect_period(longint'(1) << (8 - c), $sformatf("R3 code %0d", c));
    end
    wr(4'd7);
    expect_period(1, "R2 code 7");

    // R6: display bit does not move the speed
    wr(4'b1100);
    chk(disp_en == 1'b1, "R6 display bit set", disp_en, 1);
    expect_period(16, "R6 code 4 with display on");

    // R5: strobe high, data changes ignored
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      wr_data = 4'(k);
    end
    @(negedge clk);
    chk(disp_en == 1'b1, "R5 disp_en held", disp_en, 1);
    expect_period(16, "R5 speed held");

    // R8: halt parking and phase retention at code 6 (period 40 ns)
    wr(4'd6);
    @(posedge cpu_clk);
    t0 = longint'($time);
    @(negedge clk);
    halt = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      chk(cpu_clk == 1'b0, "R8 cpu_clk parked low", cpu_clk, 0);
      chk(cpu_clk_n == 1'b1, "R8 cpu_clk_n parked high", cpu_clk_n, 1);
      @(negedge clk); #1;
      chk(cpu_clk == 1'b0 && cpu_clk_n == 1'b1, "R8 parked at negedge", cpu_clk, 0);
    end
    @(negedge clk);
    halt = 1'b0;
    @(posedge cpu_clk);
    @(posedge cpu_clk);
    tr = longint'($time);
    chk(((tr - t0) % 40) == 0, "R8/R1 phase kept across halt", (tr - t0) % 40, 0);
    expect_period(4, "R8 resume code 6");

    // R8 at full speed as well
    wr(4'd7);
    @(negedge clk);
    halt = 1'b1;
    #2;
    chk(cpu_clk == 1'b0 && cpu_clk_n == 1'b1, "R8 parked at code 7", cpu_clk, 0);
    @(posedge clk); #1;
    chk(cpu_clk == 1'b0, "R8 no pass-through while halted", cpu_clk, 0);
    @(negedge clk);
    halt = 1'b0;
    expect_period(1, "R8 resume code 7");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule